// File: doc/BRIEF.md
# I2C Master Command List Sequencer

This block drives the master side of an I2C bus from a short program of command words instead of a fixed read or write transaction. Up to eight command slots are loaded ahead of time. A start pulse runs them in slot order from slot 0. Each command is one of five kinds: start or repeated start, write bytes, read bytes, stop, or end. A write or read command carries a byte count and fields that set how the ACK bit is checked or driven.

The sequencer does not generate bus timing itself. It asks a bit-level timing engine for one bus action at a time: a start, a repeated start, a single written bit, a single read bit, or a stop. It then waits for the engine's done pulse. Transmit bytes come from the read port of a first-word-fall-through TX FIFO. Received bytes go to an RX FIFO write port. A done flag per slot and single-cycle event pulses are provided for an interrupt block.

Top module: `i2c_cmdlist_master`

## Requirements
- R1: A `go` pulse while idle starts execution at slot 0 and runs the slots in increasing order. `busy` is high from the cycle after `go` until execution stops. A `go` while busy has no effect on the running sequence.
- R2: The command word is opcode[13:11], ack_value[10], ack_expected[9], ack_check_en[8], byte_count[7:0]. The opcodes are 0 start, 1 write, 2 read, 3 stop and 4 end. The engine request codes on `eng_op` are 0 START, 1 RESTART, 2 WBIT, 3 RBIT and 4 STOP. Opcode 0 requests START when the bus is free and RESTART when a previous run ended with the bus still held.
- R3: For each byte of a write, one TX FIFO entry is popped. Its 8 bits are requested as WBIT, MSB first when `tx_lsb_first` is 0 and LSB first when it is 1. One RBIT request follows to sample the ACK.
- R4: For each byte of a read, 8 RBIT requests assemble a byte. `rx_lsb_first` = 0 means the first bit received is bit 7. The byte is pushed to the RX FIFO, then one WBIT request drives the command's ack_value.
- R5: If `rx_count` is at or above `rx_thresh` while the ACK bit of a read is driven, `rx_full_ack` is sent instead of ack_value. `rx_count` already includes the byte just pushed.
- R6: If ack_check_en is 1 and the received ACK bit differs from ack_expected, `ev_nack` pulses, a STOP is requested, execution returns to idle and the slot's done flag stays clear. With checking disabled no NACK is raised. `ack_status` always holds the last received ACK bit (0 ACK, 1 NACK).
- R7: If the TX FIFO is empty when a write byte is due, `ev_tx_udf` pulses, nothing is popped, a STOP is requested and execution returns to idle.
- R8: An end command sets its done flag, pulses `ev_end` and returns to idle without any engine request, leaving the bus held.
- R9: A stop command requests STOP. On completion it sets its done flag, pulses `ev_complete` and returns to idle.
- R10: A slot's done flag is set when its command completes and cleared by a 1 on the matching `done_clr` bit. A set and a clear of the same flag in the same cycle leave it set.
- R11: `ev_byte_done` pulses once for every byte whose ACK bit has completed without an abort.
- R12: At most one engine request is outstanding. A new request is issued only after `eng_done` for the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start pulse, runs from slot 0 |
| cmd_we | input | 1 | Command slot write enable |
| cmd_widx | input | 3 | Slot written by `cmd_we` |
| cmd_wdata | input | 14 | Command word to store |
| done_clr | input | 8 | Write-one-to-clear for the done flags |
| cmd_done | output | 8 | Per-slot done flags |
| busy | output | 1 | Sequencer is executing |
| tx_lsb_first | input | 1 | Transmit bit order, 1 = LSB first |
| rx_lsb_first | input | 1 | Receive bit order, 1 = LSB first |
| rx_thresh | input | 5 | RX FIFO level that selects the full ACK level |
| rx_full_ack | input | 1 | ACK level sent at or above the threshold |
| rx_count | input | 5 | Current RX FIFO fill level |
| tx_empty | input | 1 | TX FIFO empty |
| tx_data | input | 8 | TX FIFO head entry |
| tx_pop | output | 1 | TX FIFO read strobe |
| rx_push | output | 1 | RX FIFO write strobe |
| rx_data | output | 8 | Received byte |
| eng_req | output | 1 | Bus action request, one cycle |
| eng_op | output | 3 | Requested bus action |
| eng_wbit | output | 1 | Bit value for a WBIT request |
| eng_done | input | 1 | Engine finished the request |
| eng_rbit | input | 1 | Bit sampled by the engine, valid with `eng_done` |
| ack_status | output | 1 | Last received ACK bit |
| ev_end | output | 1 | End command reached |
| ev_complete | output | 1 | Stop command completed |
| ev_nack | output | 1 | ACK mismatch while checking |
| ev_tx_udf | output | 1 | TX FIFO empty during a write |
| ev_byte_done | output | 1 | A byte and its ACK bit completed |

## Verification
A slot's done flag can be set by command completion in the same cycle that software writes its clear bit. An end command at slot 0 makes this easy to provoke, because its completion falls in the cycle right after `go` is taken. The bench watches for `ev_end` between clock edges and raises `done_clr` for that slot in that same cycle. It then expects the flag to read 1, and a later lone clear to read 0. A second overlap is a `go` pulse during a running write. It is judged by checking that the recorded engine request stream and the done flags match a single run exactly.

// File: rtl/i2c_cmdlist_pkg.sv
package i2c_cmdlist_pkg;

  localparam int CMD_W  = 14;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    OPC_RSTART = 3'd0,
    OPC_WRITE  = 3'd1,
    OPC_READ   = 3'd2,
    OPC_STOP   = 3'd3,
    OPC_END    = 3'd4
  } opc_e;

  typedef enum logic [2:0] {
    BUS_START  = 3'd0,
    BUS_RSTART = 3'd1,
    BUS_WBIT   = 3'd2,
    BUS_RBIT   = 3'd3,
    BUS_STOP   = 3'd4
  } bus_op_e;

  typedef struct packed {
    logic [2:0]        opc;
    logic              ack_val;
    logic              ack_exp;
    logic              ack_chk;
    logic [BYTE_W-1:0] nbytes;
  } cmd_word_t;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_BYTE, S_REQ, S_WAIT, S_ABORT, S_ABORT_WAIT
  } seq_st_e;

  // bit presented on the wire for the current transmit position
  function automatic logic tx_bit(input logic [BYTE_W-1:0] b, input logic lsb);
    return lsb ? b[0] : b[BYTE_W-1];
  endfunction

  // transmit register after one bit has gone out
  function automatic logic [BYTE_W-1:0] tx_adv(input logic [BYTE_W-1:0] b, input logic lsb);
    return lsb ? {1'b0, b[BYTE_W-1:1]} : {b[BYTE_W-2:0], 1'b0};
  endfunction

  // receive register after one bit has come in
  function automatic logic [BYTE_W-1:0] rx_ins(input logic [BYTE_W-1:0] b, input logic bit_in,
                                               input logic lsb);
    return lsb ? {bit_in, b[BYTE_W-1:1]} : {b[BYTE_W-2:0], bit_in};
  endfunction

  // ACK level driven after a received byte
  function automatic logic ack_drive(input logic [7:0] cnt, input logic [7:0] thr,
                                     input logic full_lvl, input logic cmd_lvl);
    return (cnt >= thr) ? full_lvl : cmd_lvl;
  endfunction

endpackage

// File: rtl/i2c_cmdlist_slots.sv
module i2c_cmdlist_slots #(
  parameter int SLOTS = 8,
  parameter int W     = 14
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [$clog2(SLOTS)-1:0]   wr_idx,
  input  logic [W-1:0]               wr_data,
  input  logic [$clog2(SLOTS)-1:0]   rd_idx,
  output logic [W-1:0]               rd_word,
  input  logic                       set_en,
  input  logic [$clog2(SLOTS)-1:0]   set_idx,
  input  logic [SLOTS-1:0]           clr_mask,
  output logic [SLOTS-1:0]           done
);
  localparam int IW = $clog2(SLOTS);

  logic [SLOTS-1:0][W-1:0] words;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [W-1:0] w_q;
    logic         d_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        w_q <= '0;
        d_q <= 1'b0;
      end else begin
        if (wr_en && wr_idx == IW'(g)) w_q <= wr_data;
        // completion has priority over a software clear
        if (set_en && set_idx == IW'(g)) d_q <= 1'b1;
        else if (clr_mask[g])            d_q <= 1'b0;
      end
    end
    assign words[g] = w_q;
    assign done[g]  = d_q;
  end

  assign rd_word = words[rd_idx];

endmodule

// File: rtl/i2c_cmdlist_shift.sv
module i2c_cmdlist_shift
  import i2c_cmdlist_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_val,
  input  logic              adv_tx,
  input  logic              adv_rx,
  input  logic              in_bit,
  input  logic              lsb_tx,
  input  logic              lsb_rx,
  output logic              out_bit,
  output logic [BYTE_W-1:0] rx_next
);
  logic [BYTE_W-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (load)   q <= load_val;
    else if (adv_tx) q <= tx_adv(q, lsb_tx);
    else if (adv_rx) q <= rx_ins(q, in_bit, lsb_rx);
  end

  assign out_bit = tx_bit(q, lsb_tx);
  assign rx_next = rx_ins(q, in_bit, lsb_rx);

endmodule

// File: rtl/i2c_cmdlist_master.sv
module i2c_cmdlist_master
  import i2c_cmdlist_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int CNT_W = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     go,
  input  logic                     cmd_we,
  input  logic [$clog2(SLOTS)-1:0] cmd_widx,
  input  logic [13:0]              cmd_wdata,
  input  logic [SLOTS-1:0]         done_clr,
  output logic [SLOTS-1:0]         cmd_done,
  output logic                     busy,
  input  logic                     tx_lsb_first,
  input  logic                     rx_lsb_first,
  input  logic [CNT_W-1:0]         rx_thresh,
  input  logic                     rx_full_ack,
  input  logic [CNT_W-1:0]         rx_count,
  input  logic                     tx_empty,
  input  logic [7:0]               tx_data,
  output logic                     tx_pop,
  output logic                     rx_push,
  output logic [7:0]               rx_data,
  output logic                     eng_req,
  output logic [2:0]               eng_op,
  output logic                     eng_wbit,
  input  logic                     eng_done,
  input  logic                     eng_rbit,
  output logic                     ack_status,
  output logic                     ev_end,
  output logic                     ev_complete,
  output logic                     ev_nack,
  output logic                     ev_tx_udf,
  output logic                     ev_byte_done
);
  localparam int IW      = $clog2(SLOTS);
  localparam int ACK_IDX = BYTE_W;

  seq_st_e           st, st_n;
  logic [IW-1:0]     slot, slot_n;
  cmd_word_t         cur, cur_n;
  logic [BYTE_W-1:0] left, left_n;
  logic [3:0]        bidx, bidx_n;
  logic              bus_held, held_n;
  logic              ack_q, ackq_n;

  // named internal events, observed by the checker
  logic              done_set;
  logic              adv;
  logic              byte_end;
  logic              sh_load, sh_tx, sh_rx;
  logic              sh_out;
  logic [CMD_W-1:0]  rd_word;
  cmd_word_t         fetch_word;
  logic              last_slot;
  bus_op_e           op_c;

  i2c_cmdlist_slots #(.SLOTS(SLOTS), .W(CMD_W)) u_slots (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cmd_we), .wr_idx(cmd_widx), .wr_data(cmd_wdata),
    .rd_idx(slot), .rd_word(rd_word),
    .set_en(done_set), .set_idx(slot), .clr_mask(done_clr),
    .done(cmd_done)
  );

  i2c_cmdlist_shift u_shift (
    .clk(clk), .rst_n(rst_n),
    .load(sh_load), .load_val(tx_data),
    .adv_tx(sh_tx), .adv_rx(sh_rx), .in_bit(eng_rbit),
    .lsb_tx(tx_lsb_first), .lsb_rx(rx_lsb_first),
    .out_bit(sh_out), .rx_next(rx_data)
  );

  assign fetch_word = cmd_word_t'(rd_word);
  assign last_slot  = (slot == IW'(SLOTS - 1));

  always_comb begin
    st_n = st; slot_n = slot; cur_n = cur; left_n = left;
    bidx_n = bidx; held_n = bus_held; ackq_n = ack_q;
    done_set = 1'b0; adv = 1'b0; byte_end = 1'b0;
    ev_end = 1'b0; ev_complete = 1'b0; ev_nack = 1'b0;
    ev_tx_udf = 1'b0; ev_byte_done = 1'b0;
    tx_pop = 1'b0; rx_push = 1'b0;
    sh_load = 1'b0; sh_tx = 1'b0; sh_rx = 1'b0;
    case (st)
      S_IDLE: if (go) begin
        slot_n = '0;
        st_n   = S_FETCH;
      end
      S_FETCH: begin
        cur_n = fetch_word;
        case (fetch_word.opc)
          OPC_RSTART, OPC_STOP: st_n = S_REQ;
          OPC_WRITE, OPC_READ: begin
            if (fetch_word.nbytes == '0) begin
              done_set = 1'b1;
              adv      = 1'b1;
            end else begin
              left_n = fetch_word.nbytes;
              st_n   = S_BYTE;
            end
          end
          OPC_END: begin
            done_set = 1'b1;
            ev_end   = 1'b1;
            st_n     = S_IDLE;
          end
          default: begin
            done_set = 1'b1;
            adv      = 1'b1;
          end
        endcase
      end
      S_BYTE: begin
        bidx_n = '0;
        if (cur.opc == OPC_WRITE) begin
          if (tx_empty) begin
            ev_tx_udf = 1'b1;
            st_n      = S_ABORT;
          end else begin
            tx_pop  = 1'b1;
            sh_load = 1'b1;
            st_n    = S_REQ;
          end
        end else begin
          st_n = S_REQ;
        end
      end
      S_REQ: st_n = S_WAIT;
      S_WAIT: if (eng_done) begin
        case (cur.opc)
          OPC_RSTART: begin
            held_n   = 1'b1;
            done_set = 1'b1;
            adv      = 1'b1;
          end
          OPC_STOP: begin
            held_n      = 1'b0;
            done_set    = 1'b1;
            ev_complete = 1'b1;
            st_n        = S_IDLE;
          end
          OPC_WRITE: begin
            if (bidx != 4'(ACK_IDX)) begin
              sh_tx  = 1'b1;
              bidx_n = bidx + 4'd1;
              st_n   = S_REQ;
            end else begin
              ackq_n = eng_rbit;
              if (cur.ack_chk && (eng_rbit != cur.ack_exp)) begin
                ev_nack = 1'b1;
                st_n    = S_ABORT;
              end else begin
                byte_end = 1'b1;
              end
            end
          end
          OPC_READ: begin
            if (bidx != 4'(ACK_IDX)) begin
              sh_rx   = 1'b1;
              bidx_n  = bidx + 4'd1;
              rx_push = (bidx == 4'(ACK_IDX - 1));
              st_n    = S_REQ;
            end else begin
              byte_end = 1'b1;
            end
          end
          default: st_n = S_IDLE;
        endcase
      end
      S_ABORT: st_n = S_ABORT_WAIT;
      S_ABORT_WAIT: if (eng_done) begin
        held_n = 1'b0;
        st_n   = S_IDLE;
      end
      default: st_n = S_IDLE;
    endcase

    if (byte_end) begin
      ev_byte_done = 1'b1;
      left_n       = left - 1'b1;
      if (left == BYTE_W'(1)) begin
        done_set = 1'b1;
        adv      = 1'b1;
      end else begin
        st_n = S_BYTE;
      end
    end
    if (adv) begin
      if (last_slot) st_n = S_IDLE;
      else begin
        slot_n = slot + 1'b1;
        st_n   = S_FETCH;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      slot     <= '0;
      cur      <= '0;
      left     <= '0;
      bidx     <= '0;
      bus_held <= 1'b0;
      ack_q    <= 1'b0;
    end else begin
      st       <= st_n;
      slot     <= slot_n;
      cur      <= cur_n;
      left     <= left_n;
      bidx     <= bidx_n;
      bus_held <= held_n;
      ack_q    <= ackq_n;
    end
  end

  // engine request decode
  always_comb begin
    op_c = BUS_STOP;
    if (st == S_REQ) begin
      case (cur.opc)
        OPC_RSTART: op_c = bus_held ? BUS_RSTART : BUS_START;
        OPC_WRITE:  op_c = (bidx == 4'(ACK_IDX)) ? BUS_RBIT : BUS_WBIT;
        OPC_READ:   op_c = (bidx == 4'(ACK_IDX)) ? BUS_WBIT : BUS_RBIT;
        default:    op_c = BUS_STOP;
      endcase
    end
  end

  assign eng_req    = (st == S_REQ) || (st == S_ABORT);
  assign eng_op     = op_c;
  assign eng_wbit   = (cur.opc == OPC_READ)
                      ? ack_drive(8'(rx_count), 8'(rx_thresh), rx_full_ack, cur.ack_val)
                      : sh_out;
  assign busy       = (st != S_IDLE);
  assign ack_status = ack_q;

endmodule

// File: rtl/i2c_cmdlist_checks.sv
module i2c_cmdlist_checks #(
  parameter int SLOTS = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     busy,
  input logic                     eng_req,
  input logic [2:0]               eng_op,
  input logic                     eng_done,
  input logic                     tx_pop,
  input logic                     tx_empty,
  input logic                     rx_push,
  input logic                     ev_end,
  input logic                     ev_complete,
  input logic                     ev_nack,
  input logic                     ev_tx_udf,
  input logic                     ev_byte_done,
  input logic                     done_set,
  input logic [$clog2(SLOTS)-1:0] set_idx,
  input logic [SLOTS-1:0]         cmd_done
);
  logic                     outstanding;
  logic [$clog2(SLOTS)-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outstanding <= 1'b0;
      idx_q       <= '0;
    end else begin
      if (eng_req)       outstanding <= 1'b1;
      else if (eng_done) outstanding <= 1'b0;
      idx_q <= set_idx;
    end
  end

  a_r12_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req |-> !outstanding);

  a_r7_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> !tx_empty);

  a_r1_idle_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!eng_req && !tx_pop && !rx_push));

  a_r6_nack_then_stop: assert property (@(posedge clk) disable iff (!rst_n)
    ev_nack |=> (eng_req && eng_op == 3'd4));

  a_r7_underflow_then_stop: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_udf |=> (eng_req && eng_op == 3'd4));

  a_r8_end_goes_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ev_end |=> !busy);

  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    done_set |=> cmd_done[idx_q]);

  a_r11_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_byte_done, ev_nack, ev_tx_udf, ev_end, ev_complete}));

endmodule

bind i2c_cmdlist_master i2c_cmdlist_checks #(.SLOTS(SLOTS)) u_checks (
  .clk(clk), .rst_n(rst_n), .busy(busy),
  .eng_req(eng_req), .eng_op(eng_op), .eng_done(eng_done),
  .tx_pop(tx_pop), .tx_empty(tx_empty), .rx_push(rx_push),
  .ev_end(ev_end), .ev_complete(ev_complete), .ev_nack(ev_nack),
  .ev_tx_udf(ev_tx_udf), .ev_byte_done(ev_byte_done),
  .done_set(done_set), .set_idx(slot), .cmd_done(cmd_done)
);

// File: tb/i2c_cmdlist_master_test.sv
module i2c_cmdlist_master_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic go = 0, cmd_we = 0;
  logic [2:0] cmd_widx = 0;
  logic [13:0] cmd_wdata = 0;
  logic [7:0] done_clr = 0, cmd_done;
  logic busy, tx_lsb_first = 0, rx_lsb_first = 0, rx_full_ack = 0;
  logic [4:0] rx_thresh = 5'd31, rx_count;
  logic tx_empty, tx_pop, rx_push;
  logic [7:0] tx_data, rx_data;
  logic eng_req, eng_wbit, eng_done = 0, eng_rbit = 0, ack_status;
  logic [2:0] eng_op;
  logic ev_end, ev_complete, ev_nack, ev_tx_udf, ev_byte_done;

  i2c_cmdlist_master uut (
    .clk(clk), .rst_n(rst_n), .go(go), .cmd_we(cmd_we), .cmd_widx(cmd_widx),
    .cmd_wdata(cmd_wdata), .done_clr(done_clr), .cmd_done(cmd_done), .busy(busy),
    .tx_lsb_first(tx_lsb_first), .rx_lsb_first(rx_lsb_first), .rx_thresh(rx_thresh),
    .rx_full_ack(rx_full_ack), .rx_count(rx_count), .tx_empty(tx_empty),
    .tx_data(tx_data), .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_data),
    .eng_req(eng_req), .eng_op(eng_op), .eng_wbit(eng_wbit), .eng_done(eng_done),
    .eng_rbit(eng_rbit), .ack_status(ack_status), .ev_end(ev_end),
    .ev_complete(ev_complete), .ev_nack(ev_nack), .ev_tx_udf(ev_tx_udf),
    .ev_byte_done(ev_byte_done)
  );

  int n_chk = 0, n_fail = 0;

  // bus request log, filled by the engine model
  int op_log [0:255];
  bit wb_log [0:255];
  int n_ops = 0, viol = 0;
  int exp_op [0:255];
  bit exp_bit [0:255];
  int n_exp = 0;
  bit rb [0:127];
  int rb_ptr = 0, rb_fill = 0;

  // FIFO models
  logic [7:0] txq [0:15];
  int tx_wr = 0, tx_rd = 0;
  logic [7:0] rx_got [0:15];
  int n_rx = 0;
  int c_end = 0, c_cmpl = 0, c_nack = 0, c_udf = 0, c_bdone = 0;

  assign tx_empty = (tx_rd == tx_wr);
  assign tx_data  = txq[tx_rd[3:0]];
  assign rx_count = n_rx[4:0];

  // engine and slave model
  initial begin
    @(negedge clk); #1;
    forever begin
      if (eng_req) begin
        int op;
        op = int'(eng_op);
        op_log[n_ops[7:0]] = op;
        wb_log[n_ops[7:0]] = eng_wbit;
        n_ops++;
        for (int k = 0; k < 2; k++) begin
          @(negedge clk); #1;
          if (eng_req) viol++;
        end
        eng_rbit = (op == 3) ? rb[rb_ptr[6:0]] : 1'b0;
        if (op == 3) rb_ptr++;
        eng_done = 1'b1;
        @(negedge clk); #1;
        eng_done = 1'b0;
      end else begin
        @(negedge clk); #1;
      end
    end
  end

  // FIFO and event monitor
  initial begin
    forever begin
      bit p_pop, p_push;
      @(negedge clk); #(CLK_PERIOD/4);
      p_pop = tx_pop;
      p_push = rx_push;
      if (rx_push) rx_got[n_rx[3:0]] = rx_data;
      if (ev_end) c_end++;
      if (ev_complete) c_cmpl++;
      if (ev_nack) c_nack++;
      if (ev_tx_udf) c_udf++;
      if (ev_byte_done) c_bdone++;
      @(posedge clk); #1;
      if (p_pop) tx_rd++;
      if (p_push) n_rx++;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_log(input string tag);
    int bad;
    bad = -1;
    if (n_ops != n_exp) bad = 999;
    else for (int i = 0; i < n_exp; i++)
      if (bad < 0 && (op_log[i] != exp_op[i] || (exp_op[i] == 2 && wb_log[i] != exp_bit[i])))
        bad = i;
    n_chk++;
    if (bad >= 0) begin
      n_fail++;
      $display("FAIL %s bus log: actual ops=%0d expected ops=%0d first mismatch=%0d",
               tag, n_ops, n_exp, bad);
    end
  endtask

  task automatic ex(input int op, input bit b);
    exp_op[n_exp] = op;
    exp_bit[n_exp] = b;
    n_exp++;
  endtask

  task automatic ex_wbyte(input logic [7:0] b, input bit lsb);
    for (int i = 0; i < 8; i++) ex(2, b[lsb ? i : 7 - i]);
    ex(3, 1'b0);
  endtask

  task automatic ex_rbyte(input bit ackb);
    for (int i = 0; i < 8; i++) ex(3, 1'b0);
    ex(2, ackb);
  endtask

  task automatic rb_byte(input logic [7:0] b, input bit lsb);
    for (int i = 0; i < 8; i++) begin
      rb[rb_fill] = b[lsb ? i : 7 - i];
      rb_fill++;
    end
  endtask

  task automatic rb_one(input bit b);
    rb[rb_fill] = b;
    rb_fill++;
  endtask

  task automatic fresh;
    n_ops = 0; n_exp = 0; rb_ptr = 0; rb_fill = 0; viol = 0;
    tx_wr = 0; tx_rd = 0; n_rx = 0;
    c_end = 0; c_cmpl = 0; c_nack = 0; c_udf = 0; c_bdone = 0;
    @(negedge clk); done_clr = 8'hFF;
    @(negedge clk); done_clr = 8'h00;
  endtask

  task automatic prog(input int idx, input int opc, input bit aval, input bit aexp,
                      input bit achk, input int nb);
    @(negedge clk);
    cmd_we = 1'b1;
    cmd_widx = idx[2:0];
    cmd_wdata = {opc[2:0], aval, aexp, achk, nb[7:0]};
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic run_prog(input bit extra_go);
    int t;
    @(negedge clk); go = 1'b1;
    @(negedge clk); go = 1'b0;
    if (extra_go) begin
      repeat (6) @(negedge clk);
      go = 1'b1;
      @(negedge clk); go = 1'b0;
    end
    t = 0;
    while (busy && t < 5000) begin
      @(negedge clk);
      t++;
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R10 done flags after reset", int'(cmd_done), 0);
    chk("R1 busy after reset", int'(busy), 0);
    chk("R12 no request after reset", int'(eng_req), 0);
  endtask

  task automatic t_write_msb;
    fresh();
    tx_lsb_first = 1'b0;
    txq[0] = 8'hA5; txq[1] = 8'h3C; tx_wr = 2;
    prog(0, 0, 0, 0, 0, 0);
    prog(1, 1, 0, 0, 1, 2);
    prog(2, 3, 0, 0, 0, 0);
    rb_one(1'b0); rb_one(1'b0);
    @(negedge clk); go = 1'b1;
    @(negedge clk); go = 1'b0;
    chk("R1 busy after go", int'(busy), 1);
    run_prog(1'b0);
    ex(0, 1'b0); ex_wbyte(8'hA5, 1'b0); ex_wbyte(8'h3C, 1'b0); ex(4, 1'b0);
    chk_log("R3 R2 msb-first write");
    chk("R3 bytes popped", tx_rd, 2);
    chk("R9 complete events", c_cmpl, 1);
    chk("R11 byte-done count", c_bdone, 2);
    chk("R10 done flags", int'(cmd_done), 8'h07);
    chk("R6 ack status after ACK", int'(ack_status), 0);
    chk("R12 overlapping requests", viol, 0);
  endtask

  task automatic t_write_lsb_end;
    fresh();
    tx_lsb_first = 1'b1;
    txq[0] = 8'h2D; tx_wr = 1;
    prog(0, 0, 0, 0, 0, 0);
    prog(1, 1, 0, 0, 0, 1);
    prog(2, 4, 0, 0, 0, 0);
    rb_one(1'b1);
    run_prog(1'b1);
    ex(0, 1'b0); ex_wbyte(8'h2D, 1'b1);
    chk_log("R3 R1 lsb-first write, go while busy ignored");
    chk("R6 unchecked NACK raises no event", c_nack, 0);
    chk("R6 ack status shows NACK", int'(ack_status), 1);
    chk("R8 end events", c_end, 1);
    chk("R8 done flags", int'(cmd_done), 8'h07);
    chk("R8 idle after end", int'(busy), 0);
  endtask

  task automatic t_read_restart;
    fresh();
    rx_lsb_first = 1'b0;
    rx_thresh = 5'd3;
    rx_full_ack = 1'b1;
    prog(0, 0, 0, 0, 0, 0);
    prog(1, 2, 0, 0, 0, 3);
    prog(2, 3, 0, 0, 0, 0);
    rb_byte(8'hC3, 1'b0); rb_byte(8'h5A, 1'b0); rb_byte(8'h0F, 1'b0);
    run_prog(1'b0);
    ex(1, 1'b0); ex_rbyte(1'b0); ex_rbyte(1'b0); ex_rbyte(1'b1); ex(4, 1'b0);
    chk_log("R2 R4 R5 restart and read with threshold");
    chk("R4 bytes pushed", n_rx, 3);
    chk("R4 byte 0", int'(rx_got[0]), 8'hC3);
    chk("R4 byte 1", int'(rx_got[1]), 8'h5A);
    chk("R4 byte 2", int'(rx_got[2]), 8'h0F);
    chk("R11 read byte-done count", c_bdone, 3);
    chk("R9 done flags", int'(cmd_done), 8'h07);
  endtask

  task automatic t_read_lsb;
    fresh();
    rx_lsb_first = 1'b1;
    rx_thresh = 5'd31;
    rx_full_ack = 1'b0;
    prog(0, 0, 0, 0, 0, 0);
    prog(1, 2, 1, 0, 0, 1);
    prog(2, 3, 0, 0, 0, 0);
    rb_byte(8'h96, 1'b1);
    run_prog(1'b0);
    ex(0, 1'b0); ex_rbyte(1'b1); ex(4, 1'b0);
    chk_log("R4 lsb-first read with command ACK level");
    chk("R4 lsb-first byte", int'(rx_got[0]), 8'h96);
  endtask

  task automatic t_nack_abort;
    fresh();
    tx_lsb_first = 1'b0;
    txq[0] = 8'hA5; txq[1] = 8'h3C; tx_wr = 2;
    prog(0, 0, 0, 0, 0, 0);
    prog(1, 1, 0, 0, 1, 2);
    prog(2, 3, 0, 0, 0, 0);
    rb_one(1'b1);
    run_prog(1'b0);
    ex(0, 1'b0); ex_wbyte(8'hA5, 1'b0); ex(4, 1'b0);
    chk_log("R6 NACK aborts with stop");
    chk("R6 nack events", c_nack, 1);
    chk("R6 no completion", c_cmpl, 0);
    chk("R6 done flags", int'(cmd_done), 8'h01);
    chk("R6 ack status", int'(ack_status), 1);
    chk("R6 single pop", tx_rd, 1);
    chk("R11 no byte-done on abort", c_bdone, 0);
  endtask

  task automatic t_underflow;
    fresh();
    prog(0, 0, 0, 0, 0, 0);
    prog(1, 1, 0, 0, 0, 1);
    prog(2, 3, 0, 0, 0, 0);
    run_prog(1'b0);
    ex(0, 1'b0); ex(4, 1'b0);
    chk_log("R7 underflow aborts with stop");
    chk("R7 underflow events", c_udf, 1);
    chk("R7 done flags", int'(cmd_done), 8'h01);
    chk("R7 nothing popped", tx_rd, 0);
  endtask

  task automatic t_set_clear;
    fresh();
    chk("R10 cleared flags", int'(cmd_done), 0);
    prog(0, 4, 0, 0, 0, 0);
    @(negedge clk); go = 1'b1;
    @(negedge clk); go = 1'b0;
    #1;
    chk("R8 end in first cycle", int'(ev_end), 1);
    done_clr = 8'h01;
    @(negedge clk); done_clr = 8'h00;
    #1;
    chk("R10 set wins over clear", int'(cmd_done[0]), 1);
    chk("R8 no bus request for end", n_ops, 0);
    @(negedge clk); done_clr = 8'h01;
    @(negedge clk); done_clr = 8'h00;
    #1;
    chk("R10 lone clear", int'(cmd_done[0]), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_msb();
    t_write_lsb_end();
    t_read_restart();
    t_read_lsb();
    t_nack_abort();
    t_underflow();
    t_set_clear();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule